// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Control

This block keeps the exception status of a floating-point unit. After each floating-point instruction, the datapath reports what happened as a vector of event pulses. The block turns those events into exception sources and rewrites the per-operation cause bits of a 32-bit status/control word. It accumulates sticky flag bits and compares the sources against the enable bits. When an exception is enabled, it requests a trap. The datapath also supplies per-instruction qualifiers: a matrix-vector transform, a zero input to the reciprocal square root, and an instruction that might overflow. These let some traps fire on the kind of instruction rather than only on an actual result.

Before any of that, the block checks a unit-disable bit. An instruction issued while the unit is disabled is not executed. It raises a disable exception instead: the slot variant when the instruction sits in a branch delay slot, and the general variant otherwise. Software reads the status word combinationally. It writes the word with a one-cycle write strobe, and that write outranks any operation update in the same cycle.

Event vector `op_events` and the cause/trap vectors use the bit order [5]=denormal error E, [4]=invalid V, [3]=divide-by-zero Z, [2]=overflow O, [1]=underflow U, [0]=inexact I. In the status word, flags sit in bits [4:0] and enables in bits [9:5], each in the V..I order above (V highest). Cause occupies bits [15:10] in the E..I order, and the denormal-mode bit is bit 18. All other bits read as zero.

Top module: `fpx_status_ctrl`

## Requirements
- R1: When `op_valid` and `unit_disable` are both 1, the instruction is not executed, and one cycle later exactly one of `dis_slot` (if `op_in_slot`=1) or `dis_gen` (otherwise) pulses for one cycle. The status word is not changed by the operation, and `trap_req` stays 0.
- R2: The inexact source (bit 0) is active when the inexact, overflow or underflow event is present.
- R3: Only status bits [18], [15:10], [9:5] and [4:0] are storage. All other bits read 0. The denormal error E has a cause bit but no flag and no enable bit.
- R4: For every executed operation, each cause bit [15:10] is rewritten to the operation's source value, whether 1 or 0.
- R5: For an executed operation that does not trap, each flag bit becomes the OR of its old value and its source. Flags never clear without a software write.
- R6: The E source is the denormal event gated by denormal-mode bit 18 being 0. An active E source always requests a trap, whatever the enables are.
- R7: With enable V (bit 9) set, a trap is requested on an invalid event or on a matrix-vector transform instruction (`op_xform`).
- R8: The Z source is a zero-divisor event or a zero reciprocal-square-root input (`op_rsqrt_zero`). With enable Z (bit 8) set, it requests a trap.
- R9: With enable O (bit 7) set, a trap is requested whenever `op_may_ovf` is 1, even with no overflow event.
- R10: With enable U (bit 6) or enable I (bit 5) set, the matching active source requests a trap.
- R11: A trapping operation still rewrites the cause bits but leaves the flag bits unchanged. One cycle after the operation, `trap_req` pulses and `trap_src` shows the sources that fired.
- R12: A software write stores `sw_wr_data` masked to the storage bits, and it is visible on `sw_rd_data` from the next cycle.
- R13: A software write in the same cycle as an executed operation wins, and the operation's cause and flag updates are dropped. Its trap decision, made from the pre-write enables, is still reported.
- R14: After reset the status word and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 32 | Software write value |
| sw_rd_data | output | 32 | Current status word |
| op_valid | input | 1 | A floating-point instruction completes/issues this cycle |
| unit_disable | input | 1 | Floating-point unit disabled |
| op_in_slot | input | 1 | Instruction is in a branch delay slot |
| op_events | input | 6 | Event pulses E,V,Z,O,U,I for the operation |
| op_rsqrt_zero | input | 1 | Reciprocal square root got a zero input |
| op_xform | input | 1 | Instruction is a matrix-vector transform |
| op_may_ovf | input | 1 | Instruction is one that could overflow |
| trap_req | output | 1 | One-cycle trap request |
| trap_src | output | 6 | Sources that caused the trap |
| dis_gen | output | 1 | General disable exception pulse |
| dis_slot | output | 1 | Delay-slot disable exception pulse |

## Verification
The hardest situations to reach are a trap that coincides with sticky flags already set, and a software write that lands in the same cycle as a trapping operation. In both, the flag field must show one specific history rather than the OR of events. The stimulus first fills the flags through non-trapping operations. It then enables sources by software and issues trapping operations, some with a write in the same cycle. After the directed cases, a fixed-seed random phase mixes occasional writes of random enables and the denormal mode with random events, so that trap and no-trap operations interleave over a long flag history.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NSRC    = 6;
  localparam int NFLG    = 5;
  localparam int FLG_LSB = 0;
  localparam int EN_LSB  = 5;
  localparam int CAU_LSB = 10;
  localparam int DN_BIT  = 18;
  localparam int SRC_E   = 5;
  localparam int SRC_V   = 4;
  localparam int SRC_Z   = 3;
  localparam int SRC_O   = 2;
  localparam int SRC_U   = 1;
  localparam int SRC_I   = 0;

  // Exception sources from raw events and qualifiers.
  function automatic logic [NSRC-1:0] fpx_sources(input logic [NSRC-1:0] ev,
                                                  input logic rsqrt_zero,
                                                  input logic dn);
    logic [NSRC-1:0] s;
    s        = ev;
    s[SRC_E] = ev[SRC_E] & ~dn;
    s[SRC_Z] = ev[SRC_Z] | rsqrt_zero;
    s[SRC_I] = ev[SRC_I] | ev[SRC_O] | ev[SRC_U];
    return s;
  endfunction

  // Which sources request a trap given the enables and instruction kind.
  function automatic logic [NSRC-1:0] fpx_trap_hits(input logic [NSRC-1:0] src,
                                                    input logic [NFLG-1:0] en,
                                                    input logic xform,
                                                    input logic may_ovf);
    logic [NSRC-1:0] h;
    h[SRC_E] = src[SRC_E];
    h[SRC_V] = en[SRC_V] & (src[SRC_V] | xform);
    h[SRC_Z] = en[SRC_Z] & src[SRC_Z];
    h[SRC_O] = en[SRC_O] & may_ovf;
    h[SRC_U] = en[SRC_U] & src[SRC_U];
    h[SRC_I] = en[SRC_I] & src[SRC_I];
    return h;
  endfunction

  // Mask of storage bits in a status word of width w.
  function automatic logic [63:0] fpx_store_mask();
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < NFLG; i++) begin
      m[FLG_LSB+i] = 1'b1;
      m[EN_LSB+i]  = 1'b1;
    end
    for (int i = 0; i < NSRC; i++) m[CAU_LSB+i] = 1'b1;
    m[DN_BIT] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/fpx_issue_gate.sv
module fpx_issue_gate (
  input  logic op_valid,
  input  logic unit_disable,
  input  logic op_in_slot,
  output logic exec,
  output logic dis_gen_req,
  output logic dis_slot_req
);
  always_comb begin
    exec         = op_valid & ~unit_disable;
    dis_gen_req  = op_valid &  unit_disable & ~op_in_slot;
    dis_slot_req = op_valid &  unit_disable &  op_in_slot;
  end
endmodule

// File: rtl/fpx_trap_eval.sv
module fpx_trap_eval
  import fpx_pkg::*;
(
  input  logic            exec,
  input  logic [NSRC-1:0] events,
  input  logic            rsqrt_zero,
  input  logic            xform,
  input  logic            may_ovf,
  input  logic            dn_mode,
  input  logic [NFLG-1:0] enables,
  output logic [NSRC-1:0] src,
  output logic [NSRC-1:0] hits,
  output logic            trap
);
  always_comb begin
    src  = fpx_sources(events, rsqrt_zero, dn_mode);
    hits = exec ? fpx_trap_hits(src, enables, xform, may_ovf) : '0;
    trap = |hits;
  end
endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic            exec,
  input  logic            trap,
  input  logic [NSRC-1:0] src,
  output logic [REG_W-1:0] word,
  output logic            dn_mode,
  output logic [NFLG-1:0] enables
);
  logic [NFLG-1:0] flag_q;
  logic [NFLG-1:0] en_q;
  logic [NSRC-1:0] cause_q;
  logic            dn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      dn_q    <= 1'b0;
      cause_q <= '0;
    end else if (wr_en) begin
      en_q    <= wr_data[EN_LSB +: NFLG];
      dn_q    <= wr_data[DN_BIT];
      cause_q <= wr_data[CAU_LSB +: NSRC];
    end else if (exec) begin
      cause_q <= src;
    end
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            flag_q[g] <= 1'b0;
      else if (wr_en)                        flag_q[g] <= wr_data[FLG_LSB+g];
      else if (exec && !trap && src[g])      flag_q[g] <= 1'b1;
    end
  end

  always_comb begin
    word                      = '0;
    word[FLG_LSB +: NFLG]     = flag_q;
    word[EN_LSB  +: NFLG]     = en_q;
    word[CAU_LSB +: NSRC]     = cause_q;
    word[DN_BIT]              = dn_q;
    dn_mode                   = dn_q;
    enables                   = en_q;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^(wr_data & ~fpx_store_mask()[REG_W-1:0]);
endmodule

// File: rtl/fpx_status_ctrl.sv
module fpx_status_ctrl
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_wr_en,
  input  logic [REG_W-1:0] sw_wr_data,
  output logic [REG_W-1:0] sw_rd_data,
  input  logic             op_valid,
  input  logic             unit_disable,
  input  logic             op_in_slot,
  input  logic [NSRC-1:0]  op_events,
  input  logic             op_rsqrt_zero,
  input  logic             op_xform,
  input  logic             op_may_ovf,
  output logic             trap_req,
  output logic [NSRC-1:0]  trap_src,
  output logic             dis_gen,
  output logic             dis_slot
);
  logic            exec_w;
  logic            dg_w;
  logic            ds_w;
  logic [NSRC-1:0] src_w;
  logic [NSRC-1:0] hits_w;
  logic            trap_w;
  logic            dn_w;
  logic [NFLG-1:0] en_w;

  fpx_issue_gate u_gate (
    .op_valid     (op_valid),
    .unit_disable (unit_disable),
    .op_in_slot   (op_in_slot),
    .exec         (exec_w),
    .dis_gen_req  (dg_w),
    .dis_slot_req (ds_w)
  );

  fpx_trap_eval u_eval (
    .exec       (exec_w),
    .events     (op_events),
    .rsqrt_zero (op_rsqrt_zero),
    .xform      (op_xform),
    .may_ovf    (op_may_ovf),
    .dn_mode    (dn_w),
    .enables    (en_w),
    .src        (src_w),
    .hits       (hits_w),
    .trap       (trap_w)
  );

  fpx_status_reg #(.REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (sw_wr_en),
    .wr_data (sw_wr_data),
    .exec    (exec_w),
    .trap    (trap_w),
    .src     (src_w),
    .word    (sw_rd_data),
    .dn_mode (dn_w),
    .enables (en_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_req <= 1'b0;
      trap_src <= '0;
      dis_gen  <= 1'b0;
      dis_slot <= 1'b0;
    end else begin
      trap_req <= trap_w;
      trap_src <= hits_w;
      dis_gen  <= dg_w;
      dis_slot <= ds_w;
    end
  end
endmodule

// File: rtl/fpx_status_chk.sv
module fpx_status_chk
  import fpx_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             exec,
  input logic             trap,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [NSRC-1:0]  src,
  input logic [REG_W-1:0] q,
  input logic             op_valid,
  input logic             unit_disable,
  input logic             trap_req,
  input logic             dis_gen,
  input logic             dis_slot
);
  localparam logic [REG_W-1:0] MASK = fpx_store_mask()[REG_W-1:0];

  p_dis_no_update_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && unit_disable && !wr_en |=> $stable(q) && !trap_req);

  p_one_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({trap_req, dis_gen, dis_slot}));

  p_cause_rewrite_r4: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !wr_en |=> q[CAU_LSB +: NSRC] == $past(src));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec && !trap && !wr_en |=>
      q[FLG_LSB +: NFLG] == ($past(q[FLG_LSB +: NFLG]) | $past(src[NFLG-1:0])));

  p_err_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec && src[SRC_E] |=> trap_req);

  p_trap_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    exec && trap && !wr_en |=> $stable(q[FLG_LSB +: NFLG]));

  p_sw_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> q == $past(wr_data & MASK));

  p_no_spare_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q & ~MASK) == '0);
endmodule

bind fpx_status_ctrl fpx_status_chk #(.REG_W(REG_W)) u_fpx_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .exec         (exec_w),
  .trap         (trap_w),
  .wr_en        (sw_wr_en),
  .wr_data      (sw_wr_data),
  .src          (src_w),
  .q            (sw_rd_data),
  .op_valid     (op_valid),
  .unit_disable (unit_disable),
  .trap_req     (trap_req),
  .dis_gen      (dis_gen),
  .dis_slot     (dis_slot)
);

// File: tb/test_fpx_status_ctrl.sv
module test_fpx_status_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_wr_en = 1'b0;
  logic [31:0] sw_wr_data = '0;
  logic [31:0] sw_rd_data;
  logic        op_valid = 1'b0;
  logic        unit_disable = 1'b0;
  logic        op_in_slot = 1'b0;
  logic [5:0]  op_events = '0;
  logic        op_rsqrt_zero = 1'b0;
  logic        op_xform = 1'b0;
  logic        op_may_ovf = 1'b0;
  logic        trap_req;
  logic [5:0]  trap_src;
  logic        dis_gen;
  logic        dis_slot;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model state
  logic [4:0] m_flg = '0;
  logic [4:0] m_en  = '0;
  logic [5:0] m_cau = '0;
  logic       m_dn  = 1'b0;

  always #4 clk = ~clk;

  fpx_status_ctrl i_fpx_status_ctrl (.*);

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = 32'd0;
    w[4:0]   = m_flg;
    w[9:5]   = m_en;
    w[15:10] = m_cau;
    w[18]    = m_dn;
    return w;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, logic [31:0] wd, bit v, bit dis, bit slot,
                      logic [5:0] ev, bit rz, bit xf, bit mo);
    logic [5:0] s, h;
    bit exec, t;
    @(negedge clk);
    sw_wr_en = wr; sw_wr_data = wd; op_valid = v; unit_disable = dis;
    op_in_slot = slot; op_events = ev; op_rsqrt_zero = rz; op_xform = xf; op_may_ovf = mo;
    exec = v && !dis;
    s[5] = ev[5] && !m_dn;
    s[4] = ev[4];
    s[3] = ev[3] || rz;
    s[2] = ev[2];
    s[1] = ev[1];
    s[0] = ev[0] || ev[1] || ev[2];
    h = '0;
    if (exec) begin
      h[5] = s[5];
      h[4] = m_en[4] && (s[4] || xf);
      h[3] = m_en[3] && s[3];
      h[2] = m_en[2] && mo;
      h[1] = m_en[1] && s[1];
      h[0] = m_en[0] && s[0];
    end
    t = (h != 0);
    if (wr) begin
      m_flg = wd[4:0]; m_en = wd[9:5]; m_cau = wd[15:10]; m_dn = wd[18];
    end else if (exec) begin
      m_cau = s;
      if (!t) m_flg = m_flg | s[4:0];
    end
    @(posedge clk);
    #1;
    chk(tag, "status", sw_rd_data, model_word());
    chk(tag, "trap_req", {31'd0, trap_req}, {31'd0, t});
    chk(tag, "trap_src", {26'd0, trap_src}, {26'd0, h});
    chk(tag, "dis_gen", {31'd0, dis_gen}, {31'd0, v && dis && !slot});
    chk(tag, "dis_slot", {31'd0, dis_slot}, {31'd0, v && dis && slot});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0F9A));
    #20 rst_n = 1'b1;
    #1;
    // R14 reset state
    chk("R14", "status", sw_rd_data, 32'd0);
    chk("R14", "outs", {28'd0, trap_req, dis_gen, dis_slot, |trap_src}, 32'd0);

    // R3 R12: write all ones, only storage bits stick
    step("R3", 1, 32'hFFFF_FFFF, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R12", 1, 32'h0000_0000, 0, 0, 0, 6'd0, 0, 0, 0);
    // R1 disable variants
    step("R1", 0, 0, 1, 1, 0, 6'h3F, 0, 0, 0);
    step("R1", 0, 0, 1, 1, 1, 6'h3F, 1, 1, 1);
    // R2 inexact from overflow / underflow
    step("R2", 0, 0, 1, 0, 0, 6'b000100, 0, 0, 0);
    step("R2", 0, 0, 1, 0, 0, 6'b000010, 0, 0, 0);
    // R4 cause rewritten to zero, R5 flags stay
    step("R4", 0, 0, 1, 0, 0, 6'b010000, 0, 0, 0);
    step("R5", 0, 0, 1, 0, 0, 6'b000000, 0, 0, 0);
    // R6 denormal traps with dn=0, not with dn=1
    step("R6", 0, 0, 1, 0, 0, 6'b100000, 0, 0, 0);
    step("R6", 1, 32'h0004_0000, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R6", 0, 0, 1, 0, 0, 6'b100000, 0, 0, 0);
    // R7 invalid enable, transform instruction alone traps
    step("R7", 1, 32'h0000_0200, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R7", 0, 0, 1, 0, 0, 6'd0, 0, 1, 0);
    step("R7", 0, 0, 1, 0, 0, 6'b010000, 0, 0, 0);
    // R8 divide-by-zero through rsqrt zero
    step("R8", 1, 32'h0000_0100, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R8", 0, 0, 1, 0, 0, 6'd0, 1, 0, 0);
    // R9 overflow possibility without event
    step("R9", 1, 32'h0000_0080, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R9", 0, 0, 1, 0, 0, 6'd0, 0, 0, 1);
    // R10 underflow and inexact enables
    step("R10", 1, 32'h0000_0040, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R10", 0, 0, 1, 0, 0, 6'b000010, 0, 0, 0);
    step("R10", 1, 32'h0000_0020, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R10", 0, 0, 1, 0, 0, 6'b000001, 0, 0, 0);
    // R11 flags already set, trapping op keeps them
    step("R11", 1, 32'h0000_0105, 0, 0, 0, 6'd0, 0, 0, 0);
    step("R11", 0, 0, 1, 0, 0, 6'b011010, 0, 0, 0);
    // R13 write and trapping op in same cycle
    step("R13", 1, 32'h0000_A412, 1, 0, 0, 6'b001000, 0, 0, 0);
    step("R13", 1, 32'h0000_0000, 1, 0, 0, 6'b111111, 0, 0, 0);

    for (int k = 0; k < 600; k++) begin
      bit wr = ($urandom % 10) == 0;
      logic [31:0] wd = $urandom & 32'h0004_03FF;
      if (($urandom % 4) == 0) wd[18] = 1'b0;
      step("R4", wr, wd, ($urandom % 4) != 0, ($urandom % 8) == 0, $urandom % 2,
           6'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0);
    end

    @(negedge clk);
    op_valid = 0; sw_wr_en = 0;
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule